// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a free-running supervision counter. Software must restart it before it reaches a terminal count. If it does not, the block emits a fixed-length reset request pulse for the chip's reset controller. The counter starts running in supervision mode as soon as power-on reset is released, so software that never touches the block will see the system restarted.

Software can instead switch the block into periodic-interrupt mode. In that mode each terminal-count event sets a sticky interrupt flag and does not request a reset. The counter wraps and keeps counting.

All control goes through one 16-bit register on a simple write strobe with a read-data output. A write takes effect only when its upper byte carries the unlock key. A write with any other upper byte is treated as a software fault and requests a reset at once. When a reset pulse ends, the control register and the counter are back at their power-up values.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset, `ctrl_rdata` reads 0x6900, `sys_rst_req` is low and `irq_flag` is low.
- R2: In supervision mode (bit 4 = 0), with the counter running, `sys_rst_req` rises exactly 2^E cycles after the count restarts. E is 15, 13, 9 or 6 for interval select code 0, 1, 2 or 3 in bits 1:0.
- R3: Every reset request pulse lasts exactly 4 clock cycles.
- R4: When a pulse ends, `ctrl_rdata` reads 0x6900 and the counter restarts from zero, so the next expiry comes 2^15 cycles later.
- R5: A write whose bits 15:8 differ from 0x5A raises `sys_rst_req` on the next clock edge, whatever the other bits hold.
- R6: `ctrl_rdata` has 0x69 in bits 15:8. Bit 7 shows hold, bit 4 shows mode and bits 1:0 show interval select. Bits 6, 5, 3 and 2 always read 0.
- R7: While hold (bit 7) is set, the counter does not advance and no expiry occurs.
- R8: An accepted write with bit 3 set restarts the count from zero. The bit is not stored.
- R9: In periodic-interrupt mode (bit 4 = 1), an expiry sets `irq_flag` without a reset request, and further expiries follow every 2^E cycles.
- R10: `irq_flag` stays set until `irq_ack` is high for one cycle, which clears it on that edge. The flag never sets in supervision mode.
- R11: Writes made while a pulse is active are ignored and do not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Control register write strobe |
| bus_wdata | input | 16 | Write data: key in 15:8, control in 7:0 |
| irq_ack | input | 1 | Clears the interval interrupt flag |
| ctrl_rdata | output | 16 | Control register read value |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| sys_rst_req | output | 1 | Reset request pulse |

## Verification
On every cycle the assertions check four things. The pulse length must be exact. A bad-key write must be followed by a request. The read word must have the right format. The interrupt flag must stay set until it is acknowledged. Only the bench scenarios can show the absolute expiry timing for each interval code, the restart after a clear and after a pulse, and that hold suppresses expiry over a window longer than the longest interval. The same applies to periodic wrap in interrupt mode and to the restore of the power-up control value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        MODE_WDOG = 1'b0,
        MODE_IVL  = 1'b1
    } wdt_mode_e;

    typedef struct packed {
        logic      hold;
        wdt_mode_e mode;
        logic [1:0] isel;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_POR = '{hold: 1'b0, mode: MODE_WDOG, isel: 2'd0};

    // Bit positions inside the control byte
    localparam int B_HOLD = 7;
    localparam int B_MODE = 4;
    localparam int B_CLR  = 3;

    function automatic wdt_cfg_t cfg_from_byte(input logic [7:0] b);
        wdt_cfg_t c;
        c.hold = b[B_HOLD];
        c.mode = wdt_mode_e'(b[B_MODE]);
        c.isel = b[1:0];
        return c;
    endfunction

    function automatic logic [15:0] read_word(input wdt_cfg_t c, input logic [7:0] key);
        return {key, c.hold, 2'b00, logic'(c.mode), 2'b00, c.isel};
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter logic [7:0] PW_KEY = 8'h5A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic        pulse_active,
    input  logic        restore,
    output wdt_cfg_t    cfg,
    output logic        clr_cmd,
    output logic        key_bad
);

    logic wr_open;
    logic key_ok;
    logic unused_bits;

    assign wr_open     = bus_wr && !pulse_active;
    assign key_ok      = (bus_wdata[15:8] == PW_KEY);
    assign key_bad     = wr_open && !key_ok;
    assign clr_cmd     = wr_open && key_ok && bus_wdata[B_CLR];
    assign unused_bits = ^{bus_wdata[6:5], bus_wdata[2]};

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            cfg <= CFG_POR;
        end else if (wr_open && key_ok) begin
            cfg <= cfg_from_byte(bus_wdata[7:0]);
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16,
    parameter int EXP0  = 15,
    parameter int EXP1  = 13,
    parameter int EXP2  = 9,
    parameter int EXP3  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic       restore,
    input  logic [1:0] isel,
    output logic       expire
);

    localparam int EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

    logic [CNT_W-1:0] tc_m1 [4];
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    for (genvar g = 0; g < 4; g++) begin : g_tc
        assign tc_m1[g] = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
    end

    assign at_end = (cnt >= tc_m1[isel]);
    assign expire = run && !clr && at_end;

    always_ff @(posedge clk) begin
        if (rst || restore || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic active,
    output logic restore
);

    localparam int LW = $clog2(RST_LEN + 1);

    logic [LW-1:0] left;

    assign active  = (left != '0);
    assign restore = (left == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (active) begin
            left <= left - 1'b1;
        end else if (trigger) begin
            left <= LW'(RST_LEN);
        end
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter logic [7:0] PW_KEY  = 8'h5A,
    parameter logic [7:0] RD_KEY  = 8'h69,
    parameter int         RST_LEN = 4,
    parameter int         CNT_W   = 16,
    parameter int         EXP0    = 15,
    parameter int         EXP1    = 13,
    parameter int         EXP2    = 9,
    parameter int         EXP3    = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic        irq_ack,
    output logic [15:0] ctrl_rdata,
    output logic        irq_flag,
    output logic        sys_rst_req
);

    wdt_cfg_t cfg;
    logic     clr_cmd;
    logic     key_bad;
    logic     expire;
    logic     active;
    logic     restore;
    logic     run;
    logic     trig;

    assign run  = !cfg.hold && !active;
    assign trig = key_bad || (expire && cfg.mode == MODE_WDOG);

    wdt_ctrl_reg #(.PW_KEY(PW_KEY)) u_reg (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .pulse_active(active),
        .restore     (restore),
        .cfg         (cfg),
        .clr_cmd     (clr_cmd),
        .key_bad     (key_bad)
    );

    wdt_counter #(
        .CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .clr    (clr_cmd),
        .restore(restore),
        .isel   (cfg.isel),
        .expire (expire)
    );

    wdt_rst_gen #(.RST_LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trigger(trig),
        .active (active),
        .restore(restore)
    );

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            irq_flag <= 1'b0;
        end else if (expire && cfg.mode == MODE_IVL) begin
            irq_flag <= 1'b1;
        end else if (irq_ack) begin
            irq_flag <= 1'b0;
        end
    end

    assign ctrl_rdata  = read_word(cfg, RD_KEY);
    assign sys_rst_req = active;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter logic [7:0] PW_KEY  = 8'h5A,
    parameter logic [7:0] RD_KEY  = 8'h69,
    parameter int         RST_LEN = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [15:0] bus_wdata,
    input logic        irq_ack,
    input logic [15:0] ctrl_rdata,
    input logic        irq_flag,
    input logic        sys_rst_req
);

    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else     run_len <= sys_rst_req ? run_len + 1'b1 : 8'd0;
    end

    // R1
    por_state_chk: assert property (@(posedge clk)
        rst |=> (ctrl_rdata == {RD_KEY, 8'h00} && !sys_rst_req && !irq_flag));

    // R3
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> run_len < 8'(RST_LEN));

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_req) |-> run_len == 8'(RST_LEN));

    // R5
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[15:8] != PW_KEY && !sys_rst_req) |=> sys_rst_req);

    // R6
    rd_format_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[15:8] == RD_KEY && ctrl_rdata[6:5] == 2'b00 && ctrl_rdata[3:2] == 2'b00);

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_ack && !sys_rst_req) |=> irq_flag);

endmodule

bind wdt_guard wdt_guard_chk #(
    .PW_KEY(PW_KEY), .RD_KEY(RD_KEY), .RST_LEN(RST_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq_ack    (irq_ack),
    .ctrl_rdata (ctrl_rdata),
    .irq_flag   (irq_flag),
    .sys_rst_req(sys_rst_req)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic        irq_ack = 1'b0;
    logic [15:0] ctrl_rdata;
    logic        irq_flag;
    logic        sys_rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_guard dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .irq_ack(irq_ack), .ctrl_rdata(ctrl_rdata), .irq_flag(irq_flag),
        .sys_rst_req(sys_rst_req)
    );

    function automatic int tc_of(input int code);
        int e;
        case (code)
            0: e = 15;
            1: e = 13;
            2: e = 9;
            default: e = 6;
        endcase
        return 1 << e;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Expect the pulse to rise n edges from now, last 4 cycles, then restore
    task automatic pulse_at(input int n, input string tag);
        tick(n - 1);
        chk(sys_rst_req == 1'b0, {tag, " R2 early"}, sys_rst_req, 0);
        tick(1);
        chk(sys_rst_req == 1'b1, {tag, " R2 on time"}, sys_rst_req, 1);
        chk(irq_flag == 1'b0, {tag, " R10 no irq in wdog"}, irq_flag, 0);
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk(sys_rst_req == 1'b1, {tag, " R3 held"}, sys_rst_req, 1);
        end
        tick(1);
        chk(sys_rst_req == 1'b0, {tag, " R3 ends"}, sys_rst_req, 0);
        chk(ctrl_rdata == 16'h6900, {tag, " R4 restore"}, ctrl_rdata, 16'h6900);
    endtask

    initial begin
        int miss;
        tick(3);
        rst = 1'b0;
        chk(ctrl_rdata == 16'h6900, "R1 rdata", ctrl_rdata, 16'h6900);
        chk(sys_rst_req == 1'b0, "R1 req", sys_rst_req, 0);
        chk(irq_flag == 1'b0, "R1 irq", irq_flag, 0);

        // Power-up expiry at code 0, then restart after restore
        pulse_at(tc_of(0), "por");
        pulse_at(tc_of(0), "R4 restart");

        // R6 readback format with hold set
        wr(16'h5A9F);
        chk(ctrl_rdata == 16'h6993, "R6 read 9F", ctrl_rdata, 16'h6993);
        wr(16'h5AFF);
        chk(ctrl_rdata == 16'h6993, "R6 read FF", ctrl_rdata, 16'h6993);

        // R7 hold in supervision mode across a window above the longest interval
        wr(16'h5A80);
        miss = 0;
        for (int c = 0; c < tc_of(0) + 300; c++) begin
            tick(1);
            if (sys_rst_req || irq_flag) miss++;
        end
        chk(miss == 0, "R7 hold no expiry", miss, 0);
        chk(ctrl_rdata == 16'h6980, "R7 hold read", ctrl_rdata, 16'h6980);

        // R8 clear + R2 sweep over codes 1..3
        for (int s = 1; s < 4; s++) begin
            wr(16'h5A08 | 16'(s));
            pulse_at(tc_of(s), $sformatf("R8 sweep code %0d", s));
        end

        // R8 clear midway restarts the count
        wr(16'h5A0B);
        tick(40);
        wr(16'h5A0B);
        pulse_at(tc_of(3), "R8 mid clear");

        // R5 bad key and R11 write during the pulse
        wr(16'hA500);
        chk(sys_rst_req == 1'b1, "R5 bad key", sys_rst_req, 1);
        wr(16'h6900);
        chk(sys_rst_req == 1'b1, "R11 held", sys_rst_req, 1);
        tick(2);
        chk(sys_rst_req == 1'b1, "R11 held 4th", sys_rst_req, 1);
        tick(1);
        chk(sys_rst_req == 1'b0, "R11 not extended", sys_rst_req, 0);
        chk(ctrl_rdata == 16'h6900, "R5 R4 restore", ctrl_rdata, 16'h6900);

        // R9 periodic interrupt mode, R10 ack
        wr(16'h5A1B);
        tick(tc_of(3) - 1);
        chk(irq_flag == 1'b0, "R9 early", irq_flag, 0);
        tick(1);
        chk(irq_flag == 1'b1, "R9 set", irq_flag, 1);
        chk(sys_rst_req == 1'b0, "R9 no reset", sys_rst_req, 0);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        chk(irq_flag == 1'b0, "R10 ack clears", irq_flag, 0);
        tick(tc_of(3) - 2);
        chk(irq_flag == 1'b0, "R9 second early", irq_flag, 0);
        tick(1);
        chk(irq_flag == 1'b1, "R9 second expiry", irq_flag, 1);
        tick(3 * tc_of(3));
        chk(irq_flag == 1'b1, "R10 sticky", irq_flag, 1);
        chk(sys_rst_req == 1'b0, "R9 still no reset", sys_rst_req, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule